// File: doc/BRIEF.md
# Serial preamble packet framer

The framer takes in one pseudo-random bit on each rising clock edge, from a serial generator that keeps running, while an enable input is high. It builds a 96-bit preamble from these bits. When the 96th bit arrives, it forms a 136-bit frame in one step. The captured preamble sits at the top of the frame, and four fixed fields follow it below: a 16-bit start word, a length byte, a payload byte and a closing byte. The frame appears on a parallel output, together with a valid strobe that lasts one cycle.

Capture starts again at once for the next preamble. The frame output keeps its last value until another frame is complete. A busy flag shows that a preamble has started but is not yet finished. Downstream logic treats the valid strobe as the moment to take the whole frame.

Top module: `preamble_framer`

## Requirements
- R1: While rst_ni is low, frame_o is all zeros, valid_o is 0 and busy_o is 0.
- R2: Each rising edge with enable_i high captures bit_i. The first captured bit of a preamble appears at frame_o[135] and the 96th at frame_o[40], in capture order.
- R3: In every completed frame, frame_o[39:24] is 16'b0101010100001010, frame_o[23:16] is 8'b00101110, frame_o[15:8] is 8'b01110010 and frame_o[7:0] is 8'b10111110.
- R4: valid_o goes high in the cycle right after the edge that captures the 96th bit, and only then. It stays high for exactly one cycle.
- R5: On edges with enable_i low, bit_i is ignored and the capture position does not change.
- R6: The first enabled bit after a frame completes is the first bit of the next preamble.
- R7: frame_o changes only in a cycle where valid_o is high, and otherwise holds its last frame.
- R8: busy_o is high exactly when the current preamble holds 1 to 95 captured bits. It is low in the valid cycle.
- R9: If reset is asserted in the middle of a preamble, the partial bits are discarded, and the next frame uses only bits captured after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Capture qualifier for bit_i |
| bit_i | input | 1 | Serial random bit |
| frame_o | output | 136 | Assembled frame, first preamble bit at MSB |
| valid_o | output | 1 | One-cycle strobe when a new frame is presented |
| busy_o | output | 1 | Preamble partially captured |

## Verification
The bench feeds the framer several kinds of input:
- Back-to-back preambles from a 16-bit LFSR in the bench. These exercise bit ordering and the restart between frames.
- An all-ones preamble and an all-zeros preamble. These separate true per-bit capture from a design that copies one sampled value across the whole preamble.
- A preamble broken by enable-low gaps, with bit_i toggling during the gaps. This shows whether disabled edges are ignored and whether the strobe waits for the 96th enabled bit.
- A reset in the middle of a preamble. This confirms that the partial bits do not leak into the next frame.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int unsigned PRE_W  = 96;
  localparam int unsigned TAIL_W = 40;
  localparam logic [15:0] SOF_WORD = 16'b0101010100001010;
  localparam logic [7:0]  LEN_BYTE = 8'b00101110;
  localparam logic [7:0]  PAY_BYTE = 8'b01110010;
  localparam logic [7:0]  TRL_BYTE = 8'b10111110;
  localparam logic [TAIL_W-1:0] TAIL = {SOF_WORD, LEN_BYTE, PAY_BYTE, TRL_BYTE};
endpackage

// File: rtl/fr_bit_counter.sv
module fr_bit_counter #(
  parameter  int unsigned LIMIT = 96,
  localparam int unsigned CW    = $clog2(LIMIT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  assign wrap_o = step_i && (cnt_o == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (wrap_o) cnt_o <= '0;
    else if (step_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/fr_shift_reg.sv
// Holds the first W-1 bits; the last bit is taken straight from the input.
module fr_shift_reg #(
  parameter int unsigned W = 96
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         bit_i,
  output logic [W-2:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (step_i) q_o <= {q_o[W-3:0], bit_i};
  end
endmodule

// File: rtl/fr_frame_reg.sv
module fr_frame_reg #(
  parameter  int unsigned PRE_W = 96,
  localparam int unsigned FW    = PRE_W + framer_pkg::TAIL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic [FW-1:0]    frame_o,
  output logic             valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) frame_o <= {pre_i, framer_pkg::TAIL};
    end
  end
endmodule

// File: rtl/preamble_framer.sv
module preamble_framer #(
  parameter  int unsigned PRE_W   = framer_pkg::PRE_W,
  localparam int unsigned FRAME_W = PRE_W + framer_pkg::TAIL_W,
  localparam int unsigned CNT_W   = $clog2(PRE_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               valid_o,
  output logic               busy_o
);
  logic [CNT_W-1:0] cnt;
  logic             last;
  logic [PRE_W-2:0] head;

  fr_bit_counter #(.LIMIT(PRE_W)) cnt_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (enable_i),
    .cnt_o  (cnt),
    .wrap_o (last)
  );

  fr_shift_reg #(.W(PRE_W)) shift_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (enable_i),
    .bit_i  (bit_i),
    .q_o    (head)
  );

  fr_frame_reg #(.PRE_W(PRE_W)) frame_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (last),
    .pre_i   ({head, bit_i}),
    .frame_o (frame_o),
    .valid_o (valid_o)
  );

  assign busy_o = (cnt != '0);
endmodule

// File: rtl/preamble_framer_chk.sv
module preamble_framer_chk #(
  parameter  int unsigned PRE_W   = 96,
  localparam int unsigned FRAME_W = PRE_W + 40
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               enable_i,
  input logic [FRAME_W-1:0] frame_o,
  input logic               valid_o,
  input logic               busy_o
);
  // R4: strobe lasts a single cycle
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R3: fixed fields below the preamble
  a_r3_tail_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> frame_o[39:0] == 40'b0101010100001010_00101110_01110010_10111110);

  // R7: frame changes only with the strobe
  a_r7_frame_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(frame_o));

  // R8: no partial preamble in the strobe cycle
  a_r8_idle_on_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);

  // R5: disabled edge moves nothing
  a_r5_enable_low_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!valid_o && $stable(busy_o)));

  // R8: busy starts only on an enabled capture
  a_r8_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(enable_i));
endmodule

bind preamble_framer preamble_framer_chk #(.PRE_W(PRE_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .enable_i (enable_i),
  .frame_o  (frame_o),
  .valid_o  (valid_o),
  .busy_o   (busy_o)
);

// File: tb/preamble_framer_tb_top.sv
`timescale 1ns/1ps
module preamble_framer_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         enable_i = 1'b0;
  logic         bit_i = 1'b0;
  logic [135:0] frame_o;
  logic         valid_o, busy_o;

  int checks = 0;
  int errors = 0;
  logic [135:0] exp_q[$];
  logic [135:0] last_frame = '0;
  logic [95:0]  pre_acc = '0;
  logic         pend = 1'b0;
  int           model_cnt = 0;
  logic [15:0]  lfsr = 16'hACE1;

  always #10 clk_i = ~clk_i;

  preamble_framer dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .bit_i    (bit_i),
    .frame_o  (frame_o),
    .valid_o  (valid_o),
    .busy_o   (busy_o)
  );

  function automatic logic lfsr_step();
    logic b;
    b = lfsr[0];
    lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    return b;
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // driver: one call per clock; the expected frame is queued on the 96th enabled bit
  task automatic drive(input logic en, input logic b);
    @(negedge clk_i);
    enable_i = en;
    bit_i    = b;
    if (en) begin
      pre_acc = {pre_acc[94:0], b};
      model_cnt++;
      if (model_cnt == 96) begin
        exp_q.push_back({pre_acc, 16'b0101010100001010, 8'b00101110,
                         8'b01110010, 8'b10111110});
        pend = 1'b1;
        model_cnt = 0;
      end
    end
  endtask

  task automatic lfsr_frame();
    for (int i = 0; i < 96; i++) drive(1'b1, lfsr_step());
  endtask

  // monitor / scoreboard
  initial forever begin
    @(posedge clk_i);
    #5;
    if (pend || valid_o) begin
      checks++;
      if (valid_o !== pend) begin
        errors++;
        $display("FAIL R4 valid_o act=%b exp=%b", valid_o, pend);
      end
    end
    if (pend) begin
      logic [135:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
      checks++;
      if (frame_o !== e) begin
        errors++;
        $display("FAIL R2/R3/R6 frame act=%h exp=%h", frame_o, e);
      end
      last_frame = e;
      pend = 1'b0;
    end else begin
      checks++;
      if (frame_o !== last_frame) begin
        errors++;
        $display("FAIL R7 frame hold act=%h exp=%h", frame_o, last_frame);
      end
    end
    checks++;
    if (busy_o !== (model_cnt != 0)) begin
      errors++;
      $display("FAIL R8 busy_o act=%b exp=%b", busy_o, (model_cnt != 0));
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    #15;
    checks++;
    if (frame_o !== '0 || valid_o !== 1'b0 || busy_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset act=%h/%b/%b exp=0/0/0", frame_o, valid_o, busy_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2, R6: back-to-back random preambles
    lfsr_frame();
    lfsr_frame();

    // R5: gaps with toggling bit_i while disabled
    for (int i = 0; i < 96; i++) begin
      drive(1'b1, lfsr_step());
      if (i % 7 == 3) begin
        drive(1'b0, 1'b1);
        drive(1'b0, 1'b0);
      end
    end
    drive(1'b0, 1'b1);

    // R2: uniform preambles tell per-bit capture from a copied sample
    for (int i = 0; i < 96; i++) drive(1'b1, 1'b1);
    for (int i = 0; i < 96; i++) drive(1'b1, 1'b0);

    // R9: reset mid-preamble, partial bits discarded
    for (int i = 0; i < 50; i++) drive(1'b1, 1'b1);
    @(negedge clk_i);
    enable_i = 1'b0;
    rst_ni = 1'b0;
    model_cnt = 0;
    pend = 1'b0;
    pre_acc = '0;
    last_frame = '0;
    exp_q.delete();
    #2;
    checks++;
    if (frame_o !== '0 || valid_o !== 1'b0 || busy_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset act=%h/%b/%b exp=0/0/0", frame_o, valid_o, busy_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    lfsr_frame();
    drive(1'b0, 1'b0);
    repeat (4) drive(1'b0, 1'b1);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4 pending frames act=%0d exp=0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule